// File: doc/BRIEF.md
# Token-Sequenced Product, Increment and Ninth Datapath

This block computes a small fixed fragment of arithmetic as dedicated operator hardware. From two unsigned operands `x` and `y` it produces a product `a = x*y`, its successor `b = a+1` and its ninth `c = a/9`. Every operator is present all the time. What orders the work is a single control bit that enters a chain of registers when `start` is sampled high. It moves one register along on every clock edge. The register it occupies in a given cycle is the current step of the schedule.

The token loads the operand registers and the output register of each operator. When it leaves the last register it raises `finish`. The multiplier and the divider each use two register stages, while the increment uses one. The increment and the first divider stage both read the finished product, so they run in the same step. Each result, once loaded, stays unchanged until the next execution reloads it. Cycle 0 is the cycle in which `start` is sampled high. The operand registers are valid from cycle 1, the product from cycle 3, the increment from cycle 4, the ninth from cycle 5, and `finish` is high in cycle 5.

Top module: `tokseq_datapath`

## Requirements
- R1: While reset is low, and until the first accepted start, `finish` is 0 and `a`, `b` and `c` are 0.
- R2: A start that is sampled high while the block is idle makes `finish` high for exactly one cycle, 5 cycles after it (cycle 5). `finish` is never high in two consecutive cycles.
- R3: `a` equals the unsigned 2W-bit product of the captured operands from cycle 3 through cycle 5.
- R4: `b` equals `a + 1` modulo 2^(2W) from cycle 4 through cycle 5.
- R5: In cycle 5, `c` equals the unsigned integer quotient of `a` divided by DIVISOR (9 by default), rounded down.
- R6: `x` and `y` are captured only at an accepted start. Changes on these ports in later cycles do not alter the results of that execution.
- R7: A start sampled high in cycles 1 to 4 of an execution is ignored and produces no extra `finish`. A start sampled high in the `finish` cycle begins a new execution at once.
- R8: After `finish`, `a`, `b` and `c` hold their values until a later execution reloads them, whatever `x` and `y` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Requests an execution; sampled at each rising edge |
| x | input | W | First operand, unsigned |
| y | input | W | Second operand, unsigned |
| finish | output | 1 | High for one cycle when all results are valid |
| a | output | 2W | Product of the captured operands |
| b | output | 2W | Product plus one, wrapped to 2W bits |
| c | output | 2W | Product divided by DIVISOR, rounded down |

## Verification
The properties place no constraint on `x` or `y`, because the block reads them only at an accepted start. They do assume that reset is applied before the first clock edge and that `start` is a synchronous input. The stimulus holds `start` low throughout reset and changes it only on falling edges. It scrambles both operands on every cycle after a launch. In some executions it holds `start` high through the busy steps, and in others it fires a new start exactly in the `finish` cycle, so that both the ignored case and the accepted back-to-back case of R7 are exercised.

// File: rtl/tokseq_pkg.sv
package tokseq_pkg;
  // Schedule levels: a register at level P is loaded by the token that sits
  // one step earlier and is valid from cycle P onward.
  localparam int LVL_IN    = 1;  // captured operands
  localparam int LVL_M1    = 2;  // split partial products
  localparam int LVL_A     = 3;  // product
  localparam int LVL_B     = 4;  // increment
  localparam int LVL_D1    = 4;  // upper-half quotient and remainder
  localparam int LVL_C     = 5;  // full quotient
  localparam int SCHED_LEN = 5;  // cycle in which finish is high
endpackage

// File: rtl/tokseq_chain.sv
module tokseq_chain #(
  parameter int SL = tokseq_pkg::SCHED_LEN
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  output logic [SL:1] tok
);
  logic [SL:1] tok_d, tok_q;

  assign tok_d[1] = launch;
  for (genvar k = 2; k <= SL; k++) begin : g_shift
    assign tok_d[k] = tok_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  assign tok = tok_q;
endmodule

// File: rtl/tokseq_mul2.sv
module tokseq_mul2 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en1,
  input  logic           en2,
  input  logic [W-1:0]   xa,
  input  logic [W-1:0]   yb,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int H  = W / 2;
  localparam int LW = W - H;

  logic [W+H-1:0]  pl_d, pl_q;
  logic [W+LW-1:0] ph_d, ph_q;
  logic [PW-1:0]   prod_d, prod_q;

  always_comb begin
    pl_d   = en1 ? (W+H)'(xa) * (W+H)'(yb[H-1:0]) : pl_q;
    ph_d   = en1 ? (W+LW)'(xa) * (W+LW)'(yb[W-1:H]) : ph_q;
    prod_d = en2 ? PW'(pl_q) + (PW'(ph_q) << H) : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_q   <= '0;
      ph_q   <= '0;
      prod_q <= '0;
    end else begin
      pl_q   <= pl_d;
      ph_q   <= ph_d;
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;
endmodule

// File: rtl/tokseq_div2.sv
module tokseq_div2 #(
  parameter int DW      = 16,
  parameter int DIVISOR = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en1,
  input  logic          en2,
  input  logic [DW-1:0] num,
  output logic [DW-1:0] quot
);
  localparam int RW    = $clog2(DIVISOR);
  localparam int SPLIT = DW / 2;
  localparam int HW    = DW - SPLIT;

  logic [HW-1:0]    qh_c, qh_d, qh_q;
  logic [RW-1:0]    rh_c, rh_d, rh_q;
  logic [SPLIT-1:0] lo_d, lo_q;
  logic [SPLIT-1:0] ql_c;
  logic [DW-1:0]    quot_d, quot_q;

  // Upper half of a restoring long division.
  always_comb begin
    logic [RW-1:0] r;
    logic [RW:0]   t;
    r    = '0;
    qh_c = '0;
    for (int i = DW - 1; i >= SPLIT; i--) begin
      t = {r, num[i]};
      if (t >= (RW+1)'(DIVISOR)) begin
        t              = t - (RW+1)'(DIVISOR);
        qh_c[i-SPLIT]  = 1'b1;
      end
      r = t[RW-1:0];
    end
    rh_c = r;
  end

  // Lower half, resumed from the registered remainder.
  always_comb begin
    logic [RW-1:0] r;
    logic [RW:0]   t;
    r    = rh_q;
    ql_c = '0;
    for (int i = SPLIT - 1; i >= 0; i--) begin
      t = {r, lo_q[i]};
      if (t >= (RW+1)'(DIVISOR)) begin
        t       = t - (RW+1)'(DIVISOR);
        ql_c[i] = 1'b1;
      end
      r = t[RW-1:0];
    end
  end

  always_comb begin
    qh_d   = en1 ? qh_c : qh_q;
    rh_d   = en1 ? rh_c : rh_q;
    lo_d   = en1 ? num[SPLIT-1:0] : lo_q;
    quot_d = en2 ? {qh_q, ql_c} : quot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qh_q   <= '0;
      rh_q   <= '0;
      lo_q   <= '0;
      quot_q <= '0;
    end else begin
      qh_q   <= qh_d;
      rh_q   <= rh_d;
      lo_q   <= lo_d;
      quot_q <= quot_d;
    end
  end

  assign quot = quot_q;
endmodule

// File: rtl/tokseq_datapath.sv
module tokseq_datapath
  import tokseq_pkg::*;
#(
  parameter int W       = 8,
  parameter int DIVISOR = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic           finish,
  output logic [2*W-1:0] a,
  output logic [2*W-1:0] b,
  output logic [2*W-1:0] c
);
  localparam int PW = 2 * W;
  localparam int SL = SCHED_LEN;

  logic [SL:1]   tok_q;
  logic [SL-1:0] lvl_en;
  logic          busy, launch;
  logic [W-1:0]  x_d, x_q, y_d, y_q;
  logic [PW-1:0] a_w, b_d, b_q, c_w;

  // The token in cycles 1..SL-1 marks an execution in flight.
  assign busy   = |tok_q[SL-1:1];
  assign launch = start & ~busy;
  // lvl_en[P-1] loads the registers of level P.
  assign lvl_en = {tok_q[SL-1:1], launch};

  tokseq_chain #(.SL(SL)) i_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .tok    (tok_q)
  );

  always_comb begin
    x_d = lvl_en[LVL_IN-1] ? x : x_q;
    y_d = lvl_en[LVL_IN-1] ? y : y_q;
    b_d = lvl_en[LVL_B-1]  ? a_w + PW'(1) : b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      b_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
      b_q <= b_d;
    end
  end

  tokseq_mul2 #(.W(W)) i_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en1   (lvl_en[LVL_M1-1]),
    .en2   (lvl_en[LVL_A-1]),
    .xa    (x_q),
    .yb    (y_q),
    .prod  (a_w)
  );

  tokseq_div2 #(.DW(PW), .DIVISOR(DIVISOR)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en1   (lvl_en[LVL_D1-1]),
    .en2   (lvl_en[LVL_C-1]),
    .num   (a_w),
    .quot  (c_w)
  );

  assign finish = tok_q[SL];
  assign a      = a_w;
  assign b      = b_q;
  assign c      = c_w;
endmodule

// File: rtl/tokseq_datapath_chk.sv
module tokseq_datapath_chk
  import tokseq_pkg::*;
#(
  parameter int W       = 8,
  parameter int DIVISOR = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 finish,
  input logic [SCHED_LEN:1]   tok_q,
  input logic [W-1:0]         x_q,
  input logic [W-1:0]         y_q,
  input logic [2*W-1:0]       a,
  input logic [2*W-1:0]       b,
  input logic [2*W-1:0]       c
);
  localparam int PW = 2 * W;
  localparam int SL = SCHED_LEN;

  // R2
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));

  // R2
  finish_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(|tok_q[SL-1:1])) |-> ##5 finish);

  // R2
  finish_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (|tok_q[SL-1:1])) |=> !tok_q[1]);

  // R6
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tok_q[SL-1:1]) |=> ($stable(x_q) && $stable(y_q)));

  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (a == PW'(x_q) * PW'(y_q)));

  // R4
  incr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (b == a + PW'(1)));

  // R5
  ninth_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (c == a / PW'(DIVISOR)));

  // R3
  product_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tok_q[SL:LVL_A+1]) |-> $stable(a));

  // R4
  incr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tok_q[SL:LVL_B+1]) |-> $stable(b));
endmodule

bind tokseq_datapath tokseq_datapath_chk #(.W(W), .DIVISOR(DIVISOR)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .finish (finish),
  .tok_q  (tok_q),
  .x_q    (x_q),
  .y_q    (y_q),
  .a      (a),
  .b      (b),
  .c      (c)
);

// File: tb/test_tokseq_datapath.sv
module test_tokseq_datapath;
  localparam int PERIOD  = 10;
  localparam int W       = 8;
  localparam int DIVISOR = 9;
  localparam int PW      = 2 * W;
  localparam int SL      = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  x, y;
  logic          finish;
  logic [PW-1:0] a, b, c;

  typedef struct {
    logic [PW-1:0] ea;
    logic [PW-1:0] eb;
    logic [PW-1:0] ec;
    int            due;
  } exp_t;

  exp_t          sbq[$];
  int            checks = 0;
  int            errors = 0;
  int            cnt    = 0;
  logic [PW-1:0] la = '0, lb = '0, lc = '0;
  logic [PW-1:0] a_d1 = '0, a_d2 = '0, b_d1 = '0;
  logic          fin_d = 1'b0;

  tokseq_datapath #(.W(W), .DIVISOR(DIVISOR)) i_tokseq_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .x      (x),
    .y      (y),
    .finish (finish),
    .a      (a),
    .b      (b),
    .c      (c)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: launch one execution and push its expected results.
  // Operands are scrambled after the launch (R6); with poke, start is held
  // high through cycles 1..4 and must be ignored (R7). Returns in cycle 4.
  task automatic run(input logic [W-1:0] xv, input logic [W-1:0] yv,
                     input bit poke);
    exp_t e;
    @(negedge clk);
    x     = xv;
    y     = yv;
    start = 1'b1;
    e.ea  = PW'(xv) * PW'(yv);
    e.eb  = e.ea + PW'(1);
    e.ec  = e.ea / PW'(DIVISOR);
    e.due = cnt + SL;
    la = e.ea; lb = e.eb; lc = e.ec;
    sbq.push_back(e);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      x     = W'($urandom);
      y     = W'($urandom);
      start = poke;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
      x     = W'($urandom);
      y     = W'($urandom);
    end
  endtask

  // Monitor: compare against the scoreboard when finish is seen.
  always @(negedge clk) begin
    if (rst_n) begin
      if (finish) begin
        chk(!fin_d, "R2 finish one cycle wide", 64'(fin_d), 64'd0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R7 finish without accepted start", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(cnt == e.due, "R2 finish cycle", 64'(cnt), 64'(e.due));
          chk(a_d2 == e.ea, "R3 R6 product at cycle 3", 64'(a_d2), 64'(e.ea));
          chk(a == e.ea, "R3 R6 product at finish", 64'(a), 64'(e.ea));
          chk(b_d1 == e.eb, "R4 increment at cycle 4", 64'(b_d1), 64'(e.eb));
          chk(b == e.eb, "R4 increment at finish", 64'(b), 64'(e.eb));
          chk(c == e.ec, "R5 ninth at finish", 64'(c), 64'(e.ec));
        end
      end else if (sbq.size() != 0 && cnt >= sbq[0].due) begin
        chk(1'b0, "R2 finish missing", 64'd0, 64'd1);
        void'(sbq.pop_front());
      end
      a_d2  = a_d1;
      a_d1  = a;
      b_d1  = b;
      fin_d = finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    x     = '0;
    y     = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(finish == 1'b0, "R1 finish in reset", 64'(finish), 64'd0);
    chk(a == '0, "R1 a in reset", 64'(a), 64'd0);
    chk(b == '0, "R1 b in reset", 64'(b), 64'd0);
    chk(c == '0, "R1 c in reset", 64'(c), 64'd0);
    rst_n = 1'b1;
    idle(3);
    chk(finish == 1'b0, "R1 finish idle after reset", 64'(finish), 64'd0);

    run('0, '0, 1'b0);          idle(3);
    run('1, '1, 1'b0);          idle(2);
    run(W'(9), W'(1), 1'b1);    // R7 ignored pokes
    run(W'(117), W'(3), 1'b0);  // R7 back-to-back start in finish cycle
    run(W'(8), W'(1), 1'b1);
    idle(6);
    // R8: results held while operands keep changing
    idle(5);
    chk(a == la, "R8 a held", 64'(a), 64'(la));
    chk(b == lb, "R8 b held", 64'(b), 64'(lb));
    chk(c == lc, "R8 c held", 64'(c), 64'(lc));
    chk(finish == 1'b0, "R8 no finish while idle", 64'(finish), 64'd0);

    for (int i = 0; i < 60; i++) begin
      run(W'($urandom), W'($urandom), (i % 3) == 0);
      if ((i % 4) != 0) idle(1 + (i % 3));
    end
    idle(8);
    chk(sbq.size() == 0, "R2 all executions finished", 64'(sbq.size()), 64'd0);
    chk(a == la, "R8 final a held", 64'(a), 64'(la));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule